// File: doc/BRIEF.md
# SD Card Identification Sequencer

This block walks an SD memory card from power-up to the identified state by issuing a fixed series of commands through a simple command engine. For each command it presents a 6-bit command index and a 32-bit argument, together with a one-cycle issue pulse. It then waits until the engine reports either completion, with a 32-bit response word, or an error.

The sequence runs in this order. First a power-up wait, then the card reset command and the voltage check with its echoed pattern. Next, a repeated pair of application-prefix and operating-condition commands, which loops until the card reports that power-up is complete. After that come the card-ID command and the relative-address command, reissued until the card returns a nonzero address. Last is the card-data command. The sequencer keeps the high-capacity flag and the relative address, and it ends with a sticky done or fail status.

A pulse on `start` launches a run from idle or after a previous run has ended. A `start` that arrives while a run is in progress has no effect.

Top module: `sd_ident_seq`

## Requirements
- R1: After `start`, no command is issued for PWRUP_CYCLES clock cycles. The first command then has index 0 and argument 0. `cmd_go` rises exactly PWRUP_CYCLES+1 cycles after the cycle in which `start` was sampled.
- R2: The second command has index 8 and argument 0x1AA. If its response is not exactly 0x1AA, `fail` is set and no further command is issued.
- R3: Next, the block sends index 55 with argument 0, followed by index 41 with argument 0x40300000. It repeats this pair while bit 31 of the index-41 response is 0.
- R4: `high_cap` takes the value of bit 30 of the index-41 response that had bit 31 set. `high_cap` is cleared when a new run starts.
- R5: After the operating-condition loop, the block issues index 2 and then index 3. `rca` holds the index-3 response with bits 15:0 forced to 0. Index 3 is reissued while bits 31:16 of that response are zero.
- R6: Finally, the block issues index 9 with `rca` as its argument. On its completion `done` is set and held.
- R7: With CHECK_PRESENT set, a `start` while `card_present` is low sets `fail` on the next cycle and issues no command.
- R8: `cmd_err` during any command sets `fail`, which holds and stops the sequence. A new `start` from the fail state begins a full new run.
- R9: With OCR_TRIES nonzero, the block sets `fail` after OCR_TRIES index-41 responses with bit 31 clear. No index-41 command is sent beyond that count.
- R10: After reset, `busy`, `done`, `fail`, `cmd_go` and `high_cap` are 0, and `rca` is 0.
- R11: A `start` pulse while `busy` is high is ignored. The command series continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (idle, done or fail state) |
| card_present | input | 1 | Card inserted indication |
| cmd_go | output | 1 | One-cycle command issue pulse |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_done | input | 1 | Command completed, `cmd_resp` valid |
| cmd_err | input | 1 | Command failed |
| cmd_resp | input | 32 | Response word |
| busy | output | 1 | Run in progress |
| done | output | 1 | Sticky success |
| fail | output | 1 | Sticky failure |
| high_cap | output | 1 | Card reported high capacity |
| rca | output | 32 | Relative address in bits 31:16, zeros below |

## Verification
The situations that are hardest to reach from the ports are the retry loops. Those are the repeated prefix-and-condition pair and the reissued address command, together with the retry limit, since a real card decides when it stops being busy. The bench models the command engine with a response script. The script answers index 41 with a chosen number of busy words, and answers index 3 with a chosen number of responses whose upper half is zero but whose lower half is nonzero, which also tests the masking. The bench logs every issued index and argument and compares the log with the series expected for that script.

// File: rtl/sd_ident_seq.sv
module sd_ident_seq #(
  parameter int PWRUP_CYCLES  = 100000,
  parameter int OCR_TRIES     = 1000,
  parameter bit CHECK_PRESENT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        card_present,
  output logic        cmd_go,
  output logic [5:0]  cmd_index,
  output logic [31:0] cmd_arg,
  input  logic        cmd_done,
  input  logic        cmd_err,
  input  logic [31:0] cmd_resp,
  output logic        busy,
  output logic        done,
  output logic        fail,
  output logic        high_cap,
  output logic [31:0] rca
);
  localparam int PW   = $clog2(PWRUP_CYCLES + 1);
  localparam int TW   = $clog2(OCR_TRIES + 2);
  localparam int PLIM = (PWRUP_CYCLES > 0) ? PWRUP_CYCLES - 1 : 0;
  localparam int TLIM = (OCR_TRIES > 0) ? OCR_TRIES - 1 : 0;

  typedef enum logic [2:0] {IDLE, PWRUP, ISSUE, WAIT, FIN, BAD} st_t;
  typedef enum logic [2:0] {K_RST, K_IF, K_APP, K_OP, K_CID, K_RCA, K_CSD} step_t;

  st_t           st;
  step_t         step;
  logic [PW-1:0] cnt;
  logic [TW-1:0] tries;

  assign cmd_go = (st == ISSUE);
  assign busy   = (st == PWRUP) || (st == ISSUE) || (st == WAIT);
  assign done   = (st == FIN);
  assign fail   = (st == BAD);

  always_comb begin
    cmd_index = 6'd0;
    cmd_arg   = 32'h0;
    case (step)
      K_IF:  begin cmd_index = 6'd8;  cmd_arg = 32'h0000_01AA; end
      K_APP: cmd_index = 6'd55;
      K_OP:  begin cmd_index = 6'd41; cmd_arg = 32'h4030_0000; end
      K_CID: cmd_index = 6'd2;
      K_RCA: cmd_index = 6'd3;
      K_CSD: begin cmd_index = 6'd9;  cmd_arg = rca; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; step <= K_RST; cnt <= '0; tries <= '0;
      high_cap <= 1'b0; rca <= 32'h0;
    end else begin
      case (st)
        IDLE, FIN, BAD: if (start) begin
          high_cap <= 1'b0; rca <= 32'h0; cnt <= '0; tries <= '0; step <= K_RST;
          st <= (CHECK_PRESENT && !card_present) ? BAD : PWRUP;
        end
        PWRUP: if (cnt == PW'(PLIM)) st <= ISSUE; else cnt <= cnt + 1'b1;
        ISSUE: st <= WAIT;
        WAIT: if (cmd_err) st <= BAD;
        else if (cmd_done) begin
          st <= ISSUE;
          case (step)
            K_RST: step <= K_IF;
            K_IF:  if (cmd_resp == 32'h0000_01AA) step <= K_APP; else st <= BAD;
            K_APP: step <= K_OP;
            K_OP:
              if (cmd_resp[31]) begin
                high_cap <= cmd_resp[30];
                step <= K_CID;
              end else if (OCR_TRIES != 0 && tries == TW'(TLIM)) st <= BAD;
              else begin
                tries <= tries + 1'b1;
                step <= K_APP;
              end
            K_CID: step <= K_RCA;
            K_RCA: begin
              rca <= {cmd_resp[31:16], 16'h0};
              if (cmd_resp[31:16] != 16'h0) step <= K_CSD;
            end
            default: st <= FIN;
          endcase
        end
        default: st <= IDLE;
      endcase
    end
  end

  a_r1_go_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> !cmd_go);
  a_r6_done_on_resp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cmd_done));
  a_r6_done_rca_set: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rca[31:16] != 16'h0));
  a_r8_fail_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> ($past(cmd_err) || $past(cmd_done) || $past(start)));
  a_r4_hc_update: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(high_cap) |-> ($past(cmd_done) || $past(start)));
  a_r11_go_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> busy);
endmodule

// File: tb/tb_sd_ident_seq.sv
module tb_sd_ident_seq;
  localparam int PWR = 20;
  localparam int TRY = 5;

  logic clk = 0, rst_n = 0, start = 0, card_present = 1;
  logic cmd_go, cmd_done = 0, cmd_err = 0;
  logic [5:0] cmd_index;
  logic [31:0] cmd_arg, cmd_resp = 0, rca;
  logic busy, done, fail, high_cap;

  sd_ident_seq #(.PWRUP_CYCLES(PWR), .OCR_TRIES(TRY), .CHECK_PRESENT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .card_present(card_present),
    .cmd_go(cmd_go), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
    .cmd_done(cmd_done), .cmd_err(cmd_err), .cmd_resp(cmd_resp),
    .busy(busy), .done(done), .fail(fail), .high_cap(high_cap), .rca(rca));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int n_cmds = 0, first_go = -1;
  logic [5:0] lidx [0:63];
  logic [31:0] larg [0:63];
  int busy_n = 0, zero_n = 0, cnt41 = 0, cnt3 = 0, pend = 0;
  logic hc = 0;
  logic [31:0] if_resp = 32'h1AA;
  int err_idx = -1;
  logic [5:0] pidx = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    cmd_done = 0; cmd_err = 0;
    if (pend != 0) begin
      pend--;
      if (pend == 0) begin
        case (pidx)
          6'd8: cmd_resp = if_resp;
          6'd41: begin
            cmd_resp = (cnt41 < busy_n) ? 32'h00FF_8000 : (32'h80FF_8000 | (32'(hc) << 30));
            cnt41++;
          end
          6'd3: begin
            cmd_resp = (cnt3 < zero_n) ? 32'h0000_0500 : 32'h1234_0500;
            cnt3++;
          end
          default: cmd_resp = 32'h0;
        endcase
        if (int'(pidx) == err_idx) cmd_err = 1; else cmd_done = 1;
      end
    end
    if (cmd_go) begin
      if (n_cmds == 0) first_go = cyc;
      if (n_cmds < 64) begin lidx[n_cmds] = cmd_index; larg[n_cmds] = cmd_arg; end
      n_cmds++;
      pidx = cmd_index; pend = 3;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic launch(output int sc);
    n_cmds = 0; first_go = -1; cnt41 = 0; cnt3 = 0;
    @(negedge clk); start = 1; sc = cyc;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 5000 && !(done || fail); i++) @(negedge clk);
  endtask

  task automatic chk_seq(input int b, input int z, input string tag);
    logic [5:0] ei [0:63];
    logic [31:0] ea [0:63];
    int n = 0;
    ei[n] = 0; ea[n] = 0; n++;
    ei[n] = 8; ea[n] = 32'h1AA; n++;
    for (int k = 0; k <= b; k++) begin
      ei[n] = 55; ea[n] = 0; n++;
      ei[n] = 41; ea[n] = 32'h4030_0000; n++;
    end
    ei[n] = 2; ea[n] = 0; n++;
    for (int k = 0; k <= z; k++) begin ei[n] = 3; ea[n] = 0; n++; end
    ei[n] = 9; ea[n] = 32'h1234_0000; n++;
    chk(n_cmds == n, {tag, " command count"}, n_cmds, n);
    for (int k = 0; k < n && k < n_cmds; k++) begin
      chk(lidx[k] == ei[k], {tag, " index"}, lidx[k], ei[k]);
      chk(larg[k] == ea[k], {tag, " argument"}, larg[k], ea[k]);
    end
  endtask

  task automatic t_reset();
    chk(!busy && !done && !fail, "R10 status after reset", {busy, done, fail}, 0);
    chk(!cmd_go, "R10 cmd_go after reset", cmd_go, 0);
    chk(!high_cap && rca == 0, "R10 capture regs after reset", rca, 0);
  endtask

  task automatic t_basic();
    int sc;
    busy_n = 2; zero_n = 0; hc = 0; if_resp = 32'h1AA; err_idx = -1; card_present = 1;
    launch(sc);
    chk(busy, "R1 busy during power-up wait", busy, 1);
    wait_end();
    chk(first_go - sc == PWR + 1, "R1 power-up delay", first_go - sc, PWR + 1);
    chk(done && !fail, "R6 done after full run", {done, fail}, 2'b10);
    chk_seq(2, 0, "R3 R5 R6 basic series");
    chk(high_cap == 0, "R4 standard capacity", high_cap, 0);
    chk(rca == 32'h1234_0000, "R5 rca captured", rca, 32'h1234_0000);
  endtask

  task automatic t_hc_rca_retry();
    int sc;
    busy_n = 0; zero_n = 2; hc = 1;
    launch(sc);
    wait_end();
    chk(done, "R6 done with retries", done, 1);
    chk_seq(0, 2, "R5 address reissue");
    chk(high_cap == 1, "R4 high capacity", high_cap, 1);
    chk(rca == 32'h1234_0000, "R5 lower half masked", rca, 32'h1234_0000);
  endtask

  task automatic t_badif();
    int sc;
    if_resp = 32'h1AB;
    launch(sc);
    wait_end();
    repeat (10) @(negedge clk);
    chk(fail && !done, "R2 bad voltage echo fails", fail, 1);
    chk(n_cmds == 2, "R2 no command after bad echo", n_cmds, 2);
    chk(high_cap == 0, "R4 high_cap cleared on new run", high_cap, 0);
    if_resp = 32'h1AA;
  endtask

  task automatic t_nocard();
    int sc;
    card_present = 0;
    launch(sc);
    chk(fail, "R7 immediate fail without card", fail, 1);
    repeat (PWR + 10) @(negedge clk);
    chk(n_cmds == 0, "R7 no command without card", n_cmds, 0);
    card_present = 1;
  endtask

  task automatic t_err();
    int sc;
    busy_n = 0; zero_n = 0; hc = 0; err_idx = 2;
    launch(sc);
    wait_end();
    repeat (10) @(negedge clk);
    chk(fail, "R8 engine error fails", fail, 1);
    chk(n_cmds == 5, "R8 sequence stops at error", n_cmds, 5);
    err_idx = -1;
    launch(sc);
    wait_end();
    chk(done, "R8 restart from fail completes", done, 1);
    chk_seq(0, 0, "R8 restart series");
  endtask

  task automatic t_timeout();
    int sc;
    busy_n = 1000;
    launch(sc);
    wait_end();
    repeat (10) @(negedge clk);
    chk(fail, "R9 retry limit fails", fail, 1);
    chk(cnt41 == TRY, "R9 condition command count", cnt41, TRY);
    chk(n_cmds == 2 + 2 * TRY, "R9 total commands", n_cmds, 2 + 2 * TRY);
    busy_n = 0;
  endtask

  task automatic t_busy_start();
    int sc;
    busy_n = 1; zero_n = 1;
    launch(sc);
    for (int i = 0; i < 2000 && n_cmds < 3; i++) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    wait_end();
    chk(done, "R11 run completes despite start", done, 1);
    chk_seq(1, 1, "R11 series unchanged");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_basic();
    t_hc_rca_retry();
    t_badif();
    t_nocard();
    t_err();
    t_timeout();
    t_busy_start();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule